// File: doc/BRIEF.md
# Floating-Point Conditional Compare Unit

This unit performs a predicated, quiet comparison of two IEEE 754 operands and produces a new set of four condition flags (N, Z, C, V). A request carries two 64-bit operand words, a 2-bit precision selector, a 4-bit condition code, a 4-bit substitute flag value and the flags currently held by the surrounding core. The unit first tests the condition code against the current flags. When the test passes, the operands are compared and the ordering (less, equal, greater or unordered) is written as flags. When the test fails, the substitute value is returned unchanged, and no comparison takes place.

Half, single and double precision are supported. Narrow operands occupy the least significant bits of the 64-bit operand words, and the upper bits are ignored. The compare is quiet: only a signaling NaN raises the invalid-operation indication, and only when the comparison actually runs. A reserved precision selector, or half precision when that support is disabled by the `HALF_EN` parameter, is reported as an undefined encoding.

The control is a two-state machine. In `ST_IDLE` no response is presented. The transition idle-to-respond is taken on any cycle with `req_valid` high. Respond-to-respond is taken when another request arrives on the following cycle. Respond-to-idle is taken when no request arrives. Each accepted request is answered on the next cycle in `ST_RESP`.

Top module: `fcc_unit`

## Requirements
- R1: Precision selector `prec_sel` encodings: 2'b00 selects single precision (bits [31:0]), 2'b01 selects double precision (bits [63:0]) and 2'b11 selects half precision (bits [15:0]); operand bits above the selected width have no effect on the result.
- R2: `prec_sel` = 2'b10, or 2'b11 when `HALF_EN` is 0, gives `undef_enc`=1 with `new_flags` equal to `cur_flags` and `invalid_op`=0, whatever the operands are.
- R3: The condition test reads `cur_flags` as {N,Z,C,V} (bit 3 = N). Codes 0 to 13 are EQ (Z), NE, CS (C), CC, MI (N), PL, VS (V), VC, HI (C and not Z), LS, GE (N equals V), LT, GT (not Z and N equals V) and LE, where each odd code is the inverse of the even code below it. Codes 14 and 15 always pass.
- R4: When the condition fails, `new_flags` equals `alt_flags` and `invalid_op` is 0, even when an operand is a signaling NaN.
- R5: An ordered compare gives `new_flags` 4'b1000 for a less than b, 4'b0110 for equal and 4'b0010 for a greater than b.
- R6: If either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered: `new_flags` = 4'b0011.
- R7: `invalid_op` is 1 exactly when a comparison runs and at least one operand is a signaling NaN (fraction MSB 0); a quiet NaN (fraction MSB 1) raises nothing.
- R8: Positive and negative zero compare equal, subnormals compare exactly without flushing, and infinities order beyond every finite value.
- R9: A request accepted with `req_valid` high is answered on the next cycle with `rsp_valid`=1; on a cycle with `rsp_valid`=0, `invalid_op` and `undef_enc` are 0.
- R10: After reset, `rsp_valid`, `new_flags`, `invalid_op` and `undef_enc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| prec_sel | input | 2 | Precision selector |
| cond_code | input | 4 | Condition code |
| alt_flags | input | 4 | Substitute flags for a failed condition |
| cur_flags | input | 4 | Current N,Z,C,V flags |
| opnd_a | input | 64 | First operand word |
| opnd_b | input | 64 | Second operand word |
| rsp_valid | output | 1 | Response strobe |
| new_flags | output | 4 | Resulting N,Z,C,V flags |
| invalid_op | output | 1 | Invalid-operation indication |
| undef_enc | output | 1 | Undefined encoding indication |

## Verification
On every cycle, the assertions check the response timing. They also check that the status outputs stay quiet while idle, that an undefined encoding never comes with an invalid operation, that an invalid operation always comes with unordered flags, and that an always-pass condition yields one of the four compare codes. The values themselves cannot be checked by a property without copying the logic. These are the ordering of particular half-precision pairs, the exact pass or fail result for all 256 condition and flag combinations, and the width selection with garbage in the unused upper bits. Only the bench's sweeps and directed cases can show them.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int OPND_W = 64;
    localparam int FLAG_W = 4;
    localparam int MAG_W  = OPND_W - 1;

    typedef enum logic [1:0] {
        PREC_SGL = 2'b00,
        PREC_DBL = 2'b01,
        PREC_BAD = 2'b10,
        PREC_HLF = 2'b11
    } prec_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             is_zero;
        logic             is_nan;
        logic             is_snan;
    } opnd_cls_t;

    localparam logic [FLAG_W-1:0] FL_LT = 4'b1000;
    localparam logic [FLAG_W-1:0] FL_EQ = 4'b0110;
    localparam logic [FLAG_W-1:0] FL_GT = 4'b0010;
    localparam logic [FLAG_W-1:0] FL_UN = 4'b0011;

endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
    import fcc_pkg::*;
(
    input  prec_e             sel,
    input  logic [OPND_W-1:0] raw,
    output opnd_cls_t         cls
);

    logic exp_ones;
    logic frac_nz;
    logic frac_msb;

    always_comb begin
        cls = '0;
        unique case (sel)
            PREC_HLF: begin
                cls.sign = raw[15];
                cls.mag  = {{(MAG_W-15){1'b0}}, raw[14:0]};
                exp_ones = &raw[14:10];
                frac_nz  = |raw[9:0];
                frac_msb = raw[9];
            end
            PREC_DBL: begin
                cls.sign = raw[63];
                cls.mag  = raw[62:0];
                exp_ones = &raw[62:52];
                frac_nz  = |raw[51:0];
                frac_msb = raw[51];
            end
            default: begin
                cls.sign = raw[31];
                cls.mag  = {{(MAG_W-31){1'b0}}, raw[30:0]};
                exp_ones = &raw[30:23];
                frac_nz  = |raw[22:0];
                frac_msb = raw[22];
            end
        endcase
        cls.is_zero = (cls.mag == '0);
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & ~frac_msb;
    end

endmodule

// File: rtl/fcc_magcmp.sv
module fcc_magcmp
    import fcc_pkg::*;
(
    input  opnd_cls_t         a,
    input  opnd_cls_t         b,
    output logic [FLAG_W-1:0] flags,
    output logic              snan_hit
);

    logic mag_lt;
    logic val_lt;

    always_comb begin
        mag_lt   = (a.mag < b.mag);
        val_lt   = a.sign ? ~mag_lt : mag_lt;
        snan_hit = a.is_snan | b.is_snan;
        if (a.is_nan || b.is_nan)
            flags = FL_UN;
        else if (a.is_zero && b.is_zero)
            flags = FL_EQ;
        else if (a.sign != b.sign)
            flags = a.sign ? FL_LT : FL_GT;
        else if (a.mag == b.mag)
            flags = FL_EQ;
        else
            flags = val_lt ? FL_LT : FL_GT;
    end

endmodule

// File: rtl/fcc_cond_eval.sv
module fcc_cond_eval
    import fcc_pkg::*;
(
    input  logic [3:0]        code,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass
);

    logic fn, fz, fc, fv;
    logic base;

    assign {fn, fz, fc, fv} = flags;

    always_comb begin
        unique case (code[3:1])
            3'd0: base = fz;
            3'd1: base = fc;
            3'd2: base = fn;
            3'd3: base = fv;
            3'd4: base = fc & ~fz;
            3'd5: base = (fn == fv);
            3'd6: base = ~fz & (fn == fv);
            default: base = 1'b1;
        endcase
        pass = (code[0] && code[3:1] != 3'd7) ? ~base : base;
    end

endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
    import fcc_pkg::*;
#(
    parameter bit HALF_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        prec_sel,
    input  logic [3:0]        cond_code,
    input  logic [FLAG_W-1:0] alt_flags,
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output logic              rsp_valid,
    output logic [FLAG_W-1:0] new_flags,
    output logic              invalid_op,
    output logic              undef_enc
);

    localparam int N_OPND = 2;

    state_e            state_q, state_d;
    prec_e             sel;
    logic [OPND_W-1:0] raw_v [N_OPND];
    opnd_cls_t         cls_v [N_OPND];
    logic [FLAG_W-1:0] cmp_flags;
    logic              snan_hit;
    logic              cond_pass;
    logic              is_undef;
    logic              cmp_en;
    logic [FLAG_W-1:0] flags_d;
    logic              inv_d;

    assign sel      = prec_e'(prec_sel);
    assign raw_v[0] = opnd_a;
    assign raw_v[1] = opnd_b;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fcc_classify u_cls (
            .sel (sel),
            .raw (raw_v[gi]),
            .cls (cls_v[gi])
        );
    end

    fcc_magcmp u_cmp (
        .a        (cls_v[0]),
        .b        (cls_v[1]),
        .flags    (cmp_flags),
        .snan_hit (snan_hit)
    );

    fcc_cond_eval u_cond (
        .code  (cond_code),
        .flags (cur_flags),
        .pass  (cond_pass)
    );

    always_comb begin
        is_undef = (sel == PREC_BAD) || (sel == PREC_HLF && !HALF_EN);
        cmp_en   = !is_undef && cond_pass;
        inv_d    = cmp_en && snan_hit;
        if (is_undef)
            flags_d = cur_flags;
        else if (cmp_en)
            flags_d = cmp_flags;
        else
            flags_d = alt_flags;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_flags  <= '0;
            invalid_op <= 1'b0;
            undef_enc  <= 1'b0;
        end else if (req_valid) begin
            new_flags  <= flags_d;
            invalid_op <= inv_d;
            undef_enc  <= is_undef;
        end else begin
            invalid_op <= 1'b0;
            undef_enc  <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/fcc_unit_chk.sv
module fcc_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] cond_code,
    input logic       rsp_valid,
    input logic [3:0] new_flags,
    input logic       invalid_op,
    input logic       undef_enc
);

    // R9
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R9
    req_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!invalid_op && !undef_enc));

    // R2
    undef_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_enc |-> !invalid_op);

    // R7
    inv_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_op |-> (new_flags == 4'b0011));

    // R5
    always_cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !undef_enc && $past(cond_code) == 4'b1110) |->
        (new_flags == 4'b1000 || new_flags == 4'b0110 ||
         new_flags == 4'b0010 || new_flags == 4'b0011));

endmodule

bind fcc_unit fcc_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cond_code  (cond_code),
    .rsp_valid  (rsp_valid),
    .new_flags  (new_flags),
    .invalid_op (invalid_op),
    .undef_enc  (undef_enc)
);

// File: tb/fcc_unit_bench.sv
`timescale 1ns/1ps
module fcc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  prec_sel = 2'b00;
    logic [3:0]  cond_code = 4'd0;
    logic [3:0]  alt_flags = 4'd0;
    logic [3:0]  cur_flags = 4'd0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        rsp_valid, invalid_op, undef_enc;
    logic [3:0]  new_flags;
    logic        nh_rsp_valid, nh_invalid_op, nh_undef_enc;
    logic [3:0]  nh_new_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    fcc_unit u_fcc_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prec_sel(prec_sel),
        .cond_code(cond_code), .alt_flags(alt_flags), .cur_flags(cur_flags),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .rsp_valid(rsp_valid),
        .new_flags(new_flags), .invalid_op(invalid_op), .undef_enc(undef_enc)
    );

    fcc_unit #(.HALF_EN(1'b0)) u_fcc_unit_nohalf (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prec_sel(prec_sel),
        .cond_code(cond_code), .alt_flags(alt_flags), .cur_flags(cur_flags),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .rsp_valid(nh_rsp_valid),
        .new_flags(nh_new_flags), .invalid_op(nh_invalid_op), .undef_enc(nh_undef_enc)
    );

    logic [15:0] hv [16] = '{16'h0000, 16'h8000, 16'h0001, 16'h8001,
                            16'h03FF, 16'h3C00, 16'hBC00, 16'h3C01,
                            16'h7BFF, 16'hFBFF, 16'h7C00, 16'hFC00,
                            16'h7E00, 16'h7C01, 16'hFD00, 16'h4000};

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got {vld,und,inv,nzcv}=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic real h2r(input logic [15:0] h);
        int  e = int'(h[14:10]);
        real r = real'(h[9:0]);
        if (e == 31) r = 1.0e300;
        else begin
            if (e != 0) r = r + 1024.0;
            for (int k = 0; k < ((e == 0) ? 1 : e); k++) r = r * 2.0;
            for (int k = 0; k < 25; k++) r = r / 2.0;
        end
        return h[15] ? -r : r;
    endfunction

    function automatic bit h_nan(input logic [15:0] h);
        return (&h[14:10]) && (|h[9:0]);
    endfunction

    function automatic bit h_snan(input logic [15:0] h);
        return h_nan(h) && !h[9];
    endfunction

    function automatic bit cond_ref(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic op(input logic [1:0] s, input logic [3:0] c, input logic [3:0] alt,
                      input logic [3:0] cur, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        req_valid = 1'b1; prec_sel = s; cond_code = c; alt_flags = alt;
        cur_flags = cur; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    task automatic cmp_case(input string tag, input logic [1:0] s, input logic [63:0] a,
                            input logic [63:0] b, input logic [3:0] ef, input bit einv);
        op(s, 4'b1110, 4'b0101, 4'b0000, a, b);
        chk(tag, {rsp_valid, undef_enc, invalid_op, new_flags}, {1'b1, 1'b0, einv, ef});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset", {rsp_valid, undef_enc, invalid_op, new_flags}, 7'b0);
        rst_n = 1'b1;

        // R5 R6 R7 R8 exhaustive half-precision pair sweep
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [3:0] ef;
                bit ei;
                real ra, rb;
                ra = h2r(hv[i]); rb = h2r(hv[j]);
                if (h_nan(hv[i]) || h_nan(hv[j])) ef = 4'b0011;
                else if (ra < rb) ef = 4'b1000;
                else if (ra == rb) ef = 4'b0110;
                else ef = 4'b0010;
                ei = h_snan(hv[i]) || h_snan(hv[j]);
                cmp_case("R5/R6/R7/R8 half pair", 2'b11,
                         {48'hDEAD_BEEF_F00D, hv[i]}, {48'h1234_5678_9ABC, hv[j]}, ef, ei);
            end
        end

        // R3 R4 condition sweep: ordered compare and sNaN operand
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] alt;
                bit p;
                alt = 4'(f) ^ 4'b1101;
                p   = cond_ref(4'(c), 4'(f));
                op(2'b11, 4'(c), alt, 4'(f), 64'h3C00, 64'h4000);
                chk("R3 cond ordered", {rsp_valid, undef_enc, invalid_op, new_flags},
                    {1'b1, 1'b0, 1'b0, p ? 4'b1000 : alt});
                op(2'b11, 4'(c), alt, 4'(f), 64'h7C01, 64'h4000);
                chk("R4 cond sNaN", {rsp_valid, undef_enc, invalid_op, new_flags},
                    {1'b1, 1'b0, p, p ? 4'b0011 : alt});
            end
        end

        // R1 single precision with garbage upper bits
        cmp_case("R1 sgl 1<2",    2'b00, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 4'b1000, 0);
        cmp_case("R8 sgl -0==+0", 2'b00, 64'hFFFF_FFFF_8000_0000, 64'h7FFF_0000_0000_0000, 4'b0110, 0);
        cmp_case("R7 sgl sNaN",   2'b00, 64'h0000_0000_7F80_0001, 64'h0000_0000_3F80_0000, 4'b0011, 1);
        cmp_case("R6 sgl qNaN",   2'b00, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 4'b0011, 0);
        cmp_case("R8 sgl subnorm",2'b00, 64'hAAAA_AAAA_0000_0001, 64'h5555_5555_0000_0002, 4'b1000, 0);
        cmp_case("R5 sgl -2<-1",  2'b00, 64'h0000_0000_C000_0000, 64'h0000_0000_BF80_0000, 4'b1000, 0);

        // R1 double precision
        cmp_case("R1 dbl 1<2",     2'b01, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 4'b1000, 0);
        cmp_case("R8 dbl -inf",    2'b01, 64'hFFF0_0000_0000_0000, 64'hFFEF_FFFF_FFFF_FFFF, 4'b1000, 0);
        cmp_case("R7 dbl sNaN",    2'b01, 64'h7FF0_0000_0000_0001, 64'h0,                   4'b0011, 1);
        cmp_case("R6 dbl qNaN",    2'b01, 64'h0,                   64'h7FF8_0000_0000_0000, 4'b0011, 0);
        cmp_case("R8 dbl -0==+0",  2'b01, 64'h8000_0000_0000_0000, 64'h0,                   4'b0110, 0);
        cmp_case("R5 dbl sub>0",   2'b01, 64'h0000_0000_0000_0001, 64'h0,                   4'b0010, 0);

        // R2 undefined selector
        op(2'b10, 4'b1110, 4'b0101, 4'b1010, 64'h7C01, 64'h7C01);
        chk("R2 sel 10", {rsp_valid, undef_enc, invalid_op, new_flags}, {1'b1, 1'b1, 1'b0, 4'b1010});
        op(2'b11, 4'b1110, 4'b0101, 4'b0110, 64'h7C01, 64'h3C00);
        chk("R2 half disabled", {nh_rsp_valid, nh_undef_enc, nh_invalid_op, nh_new_flags},
            {1'b1, 1'b1, 1'b0, 4'b0110});
        op(2'b00, 4'b1110, 4'b0101, 4'b0110, 64'h3F80_0000, 64'h4000_0000);
        chk("R2 half disabled sgl ok", {nh_rsp_valid, nh_undef_enc, nh_invalid_op, nh_new_flags},
            {1'b1, 1'b0, 1'b0, 4'b1000});

        // R9 idle after request stream ends
        op(2'b00, 4'b1110, 4'b0101, 4'b0000, 64'h7F80_0001, 64'h0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 idle", {rsp_valid, undef_enc, invalid_op, 4'b0000}, 7'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule